// File: doc/BRIEF.md
# Boot Source Selection Controller

This block runs once after every reset and picks the software that the device starts. It can pick the user application, the in-system-programming (ISP) handler, or the auto-baud serial loader. First it fetches a configuration word from flash. That word can turn off sampling of the request pin, and it can lock debug access. A free-running delay timer starts at reset release. When the timer expires, the controller samples the active-low request pin and the watchdog-overflow flag. If the request stands, and no watchdog overflow excuses it, the controller selects ISP at once. In every other case it fetches the first words of flash sector 0 in order and adds them modulo 2^32. A zero sum marks valid user code. Any other sum selects the auto-baud loader.

Flash is reached through a read port with a request/valid handshake. The read port has no fixed latency. The decision comes out as three one-hot lines together with a done level. These outputs hold until the next reset.

The state machine has five states:
- `ST_CFG` fetches the configuration word.
- `ST_HOLD` waits for the delay timer, then samples the pin.
- `ST_SCAN` fetches and adds the vector words.
- `ST_CHECK` tests the sum.
- `ST_DONE` holds the decision.

The transitions are:
- CFG→HOLD on the configuration response.
- HOLD→DONE on a valid ISP request.
- HOLD→SCAN otherwise.
- SCAN→CHECK on the response to the last word.
- CHECK→DONE always.

Top module: `boot_sel_ctrl`

## Requirements
- R1: While reset is low, `done`, `boot_user`, `boot_isp`, `boot_autobaud` and `dbg_lock` are 0. The first read after reset is issued to byte address 0x2FC (`CFG_ADDR`).
- R2: Once `rd_req` is high, it stays high with `rd_addr` unchanged until a cycle in which `rd_valid` is high.
- R3: The request pin is sampled once, on the first clock edge at which the delay timer has counted `DELAY_CYCLES` edges since reset release and the configuration word is in. The pin level before or after that edge has no effect.
- R4: If the sampled pin is low and `wdt_ovf` is low (with sampling enabled), the decision is ISP. No vector word is read, so only one read is made in total.
- R5: If the sampled pin is low while `wdt_ovf` is high, the request is ignored and the vector words are checked.
- R6: In the vector check, the controller reads byte addresses 0x00, 0x04, … 0x1C in ascending order, one word per handshake. If the 32-bit sum of the eight words, modulo 2^32, is zero, the decision is user.
- R7: If that sum is nonzero, the decision is auto-baud.
- R8: A configuration word equal to 0x4E697370 (`KEY_NO_SAMPLE`) disables pin sampling. A low pin then does not select ISP.
- R9: A configuration word equal to 0x12345678 (`KEY_LOCK`) drives `dbg_lock` high until the next reset. Any other value leaves `dbg_lock` low.
- R10: When `done` rises, exactly one of `boot_user` (code 001), `boot_isp` (010) or `boot_autobaud` (100) is high. The decision and `done` then hold, and no further read is issued, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| isp_req_n | input | 1 | ISP request pin, active low |
| wdt_ovf | input | 1 | Watchdog-overflow status flag |
| rd_req | output | 1 | Flash read request |
| rd_addr | output | ADDR_W | Flash byte address |
| rd_valid | input | 1 | Read data valid; completes the handshake |
| rd_data | input | DATA_W | Read data |
| boot_user | output | 1 | Decision: start user application |
| boot_isp | output | 1 | Decision: enter ISP handler |
| boot_autobaud | output | 1 | Decision: auto-baud serial loader |
| done | output | 1 | Decision valid and held |
| dbg_lock | output | 1 | Debug access locked |

## Verification
The bench builds the controller with `DELAY_CYCLES` = 16 and all other parameters at their defaults. The short delay lets the pin be switched four cycles before and four cycles after the sampling edge, which checks the single-sample rule in both directions within a few dozen cycles. The flash model answers with a random latency of zero to two cycles, so the handshake-hold rule is tested under stalls. Random vector tables, half of them with a corrected checksum word, are mixed with directed cases that cover sum wrap-around and each configuration key.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

    typedef enum logic [2:0] {
        ST_CFG,
        ST_HOLD,
        ST_SCAN,
        ST_CHECK,
        ST_DONE
    } bsc_state_e;

    typedef enum logic [2:0] {
        BOOT_NONE     = 3'b000,
        BOOT_USER     = 3'b001,
        BOOT_ISP      = 3'b010,
        BOOT_AUTOBAUD = 3'b100
    } boot_dec_e;

endpackage

// File: rtl/bsc_wait_timer.sv
module bsc_wait_timer #(
    parameter int unsigned DELAY_CYCLES = 36000
) (
    input  logic clk,
    input  logic rst_n,
    output logic expired
);
    localparam int unsigned CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES + 1) : 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == CNT_W'(DELAY_CYCLES));

    // R3: once the delay has elapsed it stays elapsed until reset
    p_timer_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> expired);

endmodule

// File: rtl/bsc_sum_accum.sv
module bsc_sum_accum #(
    parameter int unsigned WORDS  = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] sum,
    output logic [IDX_W-1:0]  idx,
    output logic              last
);
    localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum <= '0;
            idx <= '0;
        end else if (add_en) begin
            sum <= sum + din;
            if (!last)
                idx <= idx + 1'b1;
        end
    end

    assign last = (idx == IDX_W'(WORDS - 1));

    // R6: the running sum only moves on an accepted word
    p_sum_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !add_en |=> $stable(sum));

endmodule

// File: rtl/boot_sel_ctrl.sv
module boot_sel_ctrl
    import boot_sel_pkg::*;
#(
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned VEC_WORDS    = 8,
    parameter int unsigned DELAY_CYCLES = 36000,
    parameter logic [ADDR_W-1:0] CFG_ADDR      = ADDR_W'('h2FC),
    parameter logic [DATA_W-1:0] KEY_NO_SAMPLE = DATA_W'(32'h4E69_7370),
    parameter logic [DATA_W-1:0] KEY_LOCK      = DATA_W'(32'h1234_5678)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              isp_req_n,
    input  logic              wdt_ovf,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              boot_user,
    output logic              boot_isp,
    output logic              boot_autobaud,
    output logic              done,
    output logic              dbg_lock
);
    localparam int unsigned IDX_W = (VEC_WORDS > 1) ? $clog2(VEC_WORDS) : 1;

    bsc_state_e        state_q, state_d;
    boot_dec_e         dec_q;
    logic              done_q, lock_q, nosamp_q;
    logic              expired, add_en, isp_hit, acc_last;
    logic [DATA_W-1:0] acc_sum;
    logic [IDX_W-1:0]  acc_idx;

    bsc_wait_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .expired (expired)
    );

    bsc_sum_accum #(.WORDS(VEC_WORDS), .DATA_W(DATA_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .add_en (add_en),
        .din    (rd_data),
        .sum    (acc_sum),
        .idx    (acc_idx),
        .last   (acc_last)
    );

    assign isp_hit = !nosamp_q && !isp_req_n && !wdt_ovf;
    assign add_en  = (state_q == ST_SCAN) && rd_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_CFG;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CFG:   if (rd_valid) state_d = ST_HOLD;
            ST_HOLD:  if (expired)  state_d = isp_hit ? ST_DONE : ST_SCAN;
            ST_SCAN:  if (rd_valid && acc_last) state_d = ST_CHECK;
            ST_CHECK: state_d = ST_DONE;
            ST_DONE:  state_d = ST_DONE;
            default:  state_d = ST_CFG;
        endcase
    end

    // read port
    always_comb begin
        rd_req  = (state_q == ST_CFG) || (state_q == ST_SCAN);
        rd_addr = (state_q == ST_CFG) ? CFG_ADDR : ADDR_W'({acc_idx, 2'b00});
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q    <= BOOT_NONE;
            done_q   <= 1'b0;
            lock_q   <= 1'b0;
            nosamp_q <= 1'b0;
        end else begin
            if (state_q == ST_CFG && rd_valid) begin
                nosamp_q <= (rd_data == KEY_NO_SAMPLE);
                lock_q   <= (rd_data == KEY_LOCK);
            end
            if (state_q == ST_HOLD && expired && isp_hit) begin
                dec_q  <= BOOT_ISP;
                done_q <= 1'b1;
            end
            if (state_q == ST_CHECK) begin
                dec_q  <= (acc_sum == '0) ? BOOT_USER : BOOT_AUTOBAUD;
                done_q <= 1'b1;
            end
        end
    end

    assign boot_user     = dec_q[0];
    assign boot_isp      = dec_q[1];
    assign boot_autobaud = dec_q[2];
    assign done          = done_q;
    assign dbg_lock      = lock_q;

    // R2: request and address held until the response arrives
    p_handshake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    // R4: an ISP decision is made without fetching any vector word
    p_isp_noscan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        boot_isp |-> (acc_idx == '0));

    // R6: user decision only on a zero sum
    p_user_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
        boot_user |-> (acc_sum == '0));

    // R7: auto-baud decision only on a nonzero sum
    p_autobaud_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
        boot_autobaud |-> (acc_sum != '0));

    // R9: lock persists until reset
    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_lock |=> dbg_lock);

    // R10: exactly one decision line with done
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({boot_user, boot_isp, boot_autobaud}) == 1));

    // R10: decision held, port quiet
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable({boot_user, boot_isp, boot_autobaud}) && !rd_req));

endmodule

// File: tb/test_boot_sel_ctrl.sv
module test_boot_sel_ctrl;
    localparam int          DLY  = 16;
    localparam logic [31:0] K_NS = 32'h4E69_7370;
    localparam logic [31:0] K_LK = 32'h1234_5678;

    logic        clk = 1'b0;
    logic        rst_n, isp_req_n, wdt_ovf, rd_valid;
    logic [31:0] rd_data;
    logic        rd_req, boot_user, boot_isp, boot_autobaud, done, dbg_lock;
    logic [11:0] rd_addr;

    always #10 clk = ~clk;

    boot_sel_ctrl #(.DELAY_CYCLES(DLY)) i_boot_sel_ctrl (
        .clk(clk), .rst_n(rst_n), .isp_req_n(isp_req_n), .wdt_ovf(wdt_ovf),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .boot_user(boot_user), .boot_isp(boot_isp), .boot_autobaud(boot_autobaud),
        .done(done), .dbg_lock(dbg_lock)
    );

    logic [31:0] fw [8];
    logic [31:0] cfg_word;
    logic [11:0] alog [16];
    int          nrd, hs_err;
    int          n_chk = 0, n_bad = 0;

    function automatic logic [31:0] flash_rd(logic [11:0] a);
        if (a == 12'h2FC) return cfg_word;
        if (a < 12'h20 && a[1:0] == 2'b00) return fw[a[4:2]];
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] sum8();
        logic [31:0] s = '0;
        for (int i = 0; i < 8; i++) s = s + fw[i];
        return s;
    endfunction

    // expected code: 001 user, 010 isp, 100 auto-baud
    function automatic logic [2:0] exp_dec(logic [31:0] cw, logic pin, logic wdt);
        if (cw != K_NS && !pin && !wdt) return 3'b010;
        return (sum8() == 32'h0) ? 3'b001 : 3'b100;
    endfunction

    // flash model with random latency, also watches the handshake
    initial begin
        int  lat = 0;
        logic waiting = 1'b0;
        logic [11:0] prev_addr = '0;
        rd_valid = 1'b0;
        rd_data  = '0;
        forever begin
            @(negedge clk);
            rd_valid = 1'b0;
            if (rd_req && rst_n) begin
                if (waiting && rd_addr != prev_addr) hs_err++;
                if (lat == 0) begin
                    rd_valid = 1'b1;
                    rd_data  = flash_rd(rd_addr);
                    if (nrd < 16) alog[nrd] = rd_addr;
                    nrd++;
                    lat = int'($urandom % 3);
                    waiting = 1'b0;
                end else begin
                    lat--;
                    waiting = 1'b1;
                end
                prev_addr = rd_addr;
            end else begin
                waiting = 1'b0;
            end
        end
    end

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic run_trial(logic pin0, logic pin1, int sw, logic wdt, logic pin_at_sample);
        logic [2:0] ed, got;
        int cyc, exp_rd;
        bit scan;
        ed = exp_dec(cfg_word, pin_at_sample, wdt);
        @(negedge clk); #1;
        rst_n = 1'b0; isp_req_n = pin0; wdt_ovf = wdt;
        repeat (3) @(negedge clk);
        #1;
        chk({done, boot_user, boot_isp, boot_autobaud, dbg_lock} == 5'b0, "R1", "outputs in reset",
            32'({done, boot_user, boot_isp, boot_autobaud, dbg_lock}), 32'h0);
        rst_n = 1'b1; nrd = 0; hs_err = 0; cyc = 0;
        while (!done && cyc < DLY + 200) begin
            @(negedge clk); #1;
            cyc++;
            if (cyc == sw) isp_req_n = pin1;
        end
        got  = {boot_autobaud, boot_isp, boot_user};
        scan = (ed != 3'b010);
        exp_rd = scan ? 9 : 1;
        chk(done == 1'b1, "R10", "done reached", 32'(done), 32'h1);
        chk(got == ed, (ed == 3'b010) ? "R4" : (ed == 3'b001) ? "R6" : "R7",
            "decision", 32'(got), 32'(ed));
        chk(dbg_lock == (cfg_word == K_LK), "R9", "dbg_lock", 32'(dbg_lock), 32'(cfg_word == K_LK));
        chk(nrd == exp_rd, scan ? "R5" : "R4", "read count", 32'(nrd), 32'(exp_rd));
        chk(alog[0] == 12'h2FC, "R1", "first address", 32'(alog[0]), 32'h2FC);
        if (scan && nrd == 9)
            for (int i = 0; i < 8; i++)
                chk(alog[i+1] == 12'(i * 4), "R6", "vector address order", 32'(alog[i+1]), 32'(i * 4));
        chk(hs_err == 0, "R2", "address change while waiting", 32'(hs_err), 32'h0);
        isp_req_n = ~isp_req_n; wdt_ovf = ~wdt_ovf;
        repeat (4) @(negedge clk);
        #1;
        chk({done, boot_autobaud, boot_isp, boot_user} == {1'b1, ed} && nrd == exp_rd, "R10",
            "decision held", 32'({done, boot_autobaud, boot_isp, boot_user}), 32'({1'b1, ed}));
    endtask

    task automatic set_valid_code();
        for (int i = 0; i < 7; i++) fw[i] = $urandom;
        fw[7] = '0;
        fw[7] = -sum8();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic p, w;
        int   sel;
        void'($urandom(32'hB007));
        rst_n = 1'b0; isp_req_n = 1'b1; wdt_ovf = 1'b0; cfg_word = '0; nrd = 0; hs_err = 0;

        // R3: pin low early then high before the sampling edge -> not ISP
        set_valid_code(); cfg_word = 32'h0;
        run_trial(1'b0, 1'b1, DLY - 4, 1'b0, 1'b1);
        // R3: pin high early then low before the sampling edge -> ISP
        run_trial(1'b1, 1'b0, DLY - 4, 1'b0, 1'b0);
        // R3: pin low at sampling, high after -> ISP stays
        run_trial(1'b0, 1'b1, DLY + 4, 1'b0, 1'b0);
        // R3: pin high at sampling, low after -> user
        run_trial(1'b1, 1'b0, DLY + 4, 1'b0, 1'b1);
        // R5: pin low with watchdog overflow -> scan, user
        run_trial(1'b0, 1'b0, 0, 1'b1, 1'b0);
        // R8: sampling disabled, pin low -> user
        cfg_word = K_NS;
        run_trial(1'b0, 1'b0, 0, 1'b0, 1'b0);
        // R9: lock key, pin high
        cfg_word = K_LK;
        run_trial(1'b1, 1'b1, 0, 1'b0, 1'b1);
        // R6: wrap-around sum is zero
        cfg_word = 32'h0;
        for (int i = 0; i < 7; i++) fw[i] = 32'hFFFF_FFFF;
        fw[7] = 32'h7;
        run_trial(1'b1, 1'b1, 0, 1'b0, 1'b1);
        // R6: all-zero table
        for (int i = 0; i < 8; i++) fw[i] = 32'h0;
        run_trial(1'b1, 1'b1, 0, 1'b0, 1'b1);
        // R7: checksum off by one
        set_valid_code(); fw[7] = fw[7] + 32'h1;
        run_trial(1'b1, 1'b1, 0, 1'b0, 1'b1);

        // random trials
        for (int t = 0; t < 40; t++) begin
            for (int i = 0; i < 8; i++) fw[i] = $urandom;
            if ($urandom % 2) set_valid_code();
            sel = int'($urandom % 4);
            cfg_word = (sel == 0) ? $urandom : (sel == 1) ? K_NS : (sel == 2) ? K_LK : 32'hFFFF_FFFF;
            p = 1'($urandom % 2);
            w = 1'($urandom % 2);
            run_trial(p, p, 0, w, p);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule